// File: doc/BRIEF.md
# Edge Overlay Video Mixer

This block produces the display stream of an edge-detection pipeline. It receives the original 16-bit colour pixels at the front of the pipeline and the 1-bit edge mask at the back. It holds back the colour pixels by a fixed alignment delay, so that each one meets the mask result computed from it. It then forms each output channel from the aligned pixel, the mask bit and a 2-bit overlay mode.

The overlay mode has two independent choices. Bit 0 picks the background: black, or the original colour. Bit 1 makes every mask pixel show as pure white on top of that background. The red, green and blue fields are mixed by three instances of one per-channel mixer.

The mode is taken from its input only on a valid frame-start pixel of the mask stream. It applies to that pixel and stays fixed for the rest of the frame, so the picture never changes mode part-way down the screen. The valid, frame-start and line-start tags of the mask stream come out unchanged, aligned with the mixed pixel.

Top module: `edge_ovl_mixer`

## Requirements
- R1: While reset is asserted, `mix_rgb` is 0 and `mix_vld`, `mix_sof` and `mix_sol` are 0.
- R2: The colour pixel driven on `src_rgb` at clock edge n is the background used with the mask presented at edge n+13. The mixed result appears on the outputs after edge n+13, one cycle after its mask. Before 13 pixels have entered after reset, the background is 0.
- R3: With the effective mode 00, `mix_rgb` is 0 whatever the mask bit is.
- R4: With the effective mode 01, `mix_rgb` equals the aligned original pixel whatever the mask bit is. The fields are red [15:11], green [10:5] and blue [4:0].
- R5: With the effective mode 11, a mask bit of 1 makes every channel all ones (`mix_rgb` = 16'hFFFF). A mask bit of 0 gives the aligned original pixel.
- R6: With the effective mode 10, a mask bit of 1 gives 16'hFFFF and a mask bit of 0 gives 0.
- R7: `ovl_mode` is stored only when `msk_vld` and `msk_sof` are both 1. A change at any other time, including a frame-start flag without valid, has no effect on the output.
- R8: On the valid frame-start pixel itself, the newly presented `ovl_mode` already controls the mix of that pixel.
- R9: `mix_vld`, `mix_sof` and `mix_sol` equal `msk_vld`, `msk_sof` and `msk_sol` from one cycle earlier.
- R10: After reset, until the first valid frame start, the stored mode is 01 (original background, no white overlay).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovl_mode | input | 2 | Overlay mode: bit 0 original background, bit 1 white mask paint |
| src_rgb | input | 16 | Original colour pixel, 5/6/5, entering the alignment delay |
| msk_bit | input | 1 | Edge mask bit for the aligned pixel |
| msk_vld | input | 1 | Valid tag of the mask stream |
| msk_sof | input | 1 | Frame-start tag of the mask stream |
| msk_sol | input | 1 | Line-start tag of the mask stream |
| mix_rgb | output | 16 | Mixed display pixel |
| mix_vld | output | 1 | Valid tag, delayed one cycle |
| mix_sof | output | 1 | Frame-start tag, delayed one cycle |
| mix_sol | output | 1 | Line-start tag, delayed one cycle |

## Verification
Two things can fall in the same cycle: storing a new overlay mode at a valid frame start, and mixing the pixel that carries that frame start. The bench presents a frame start together with a mode that differs from the stored one. It then checks that the output for that very pixel already follows the new mode, and that the following pixels keep it.

The bench also changes the mode in the middle of a frame, and raises the frame-start flag without valid. It then checks that the output still follows the mode stored earlier. Every expected pixel comes from a counter-based colour pattern shifted back by 13 clock edges, under the bench's own model of the stored mode.

// File: rtl/edge_ovl_pkg.sv
package edge_ovl_pkg;

   // Overlay mode: bit 1 paints the mask white, bit 0 keeps the original colour
   typedef struct packed {
      logic white;
      logic orig_bg;
   } ovl_cfg_t;

   localparam int OVL_W = $bits(ovl_cfg_t);

endpackage

// File: rtl/edge_ovl_delay.sv
module edge_ovl_delay #(
   parameter int W     = 16,
   parameter int DEPTH = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (W < 1) begin : g_bad_w
      $error("edge_ovl_delay: W must be at least 1");
   end
   if (DEPTH < 0) begin : g_bad_depth
      $error("edge_ovl_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign dout = din;
   end else begin : g_chain
      logic [W-1:0] stg [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
         end else begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
         end
      end

      assign dout = stg[DEPTH-1];
   end

endmodule

// File: rtl/edge_ovl_cfg.sv
module edge_ovl_cfg
   import edge_ovl_pkg::*;
#(
   parameter logic [OVL_W-1:0] RST_MODE = 2'b01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OVL_W-1:0] mode_in,
   input  logic             frame_go,
   output ovl_cfg_t         cfg_eff
);

   ovl_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= ovl_cfg_t'(RST_MODE);
      else if (frame_go) cfg_q <= ovl_cfg_t'(mode_in);
   end

   // The frame-start pixel already uses the mode that is being stored
   assign cfg_eff = frame_go ? ovl_cfg_t'(mode_in) : cfg_q;

   // R7: stored mode only moves at a valid frame start
   p_hold_mid_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_go |=> $stable(cfg_q));

   // R8: a valid frame start stores the presented mode
   p_take_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go |=> (cfg_q == ovl_cfg_t'($past(mode_in))));

endmodule

// File: rtl/edge_ovl_chan.sv
module edge_ovl_chan
   import edge_ovl_pkg::*;
#(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] bg_in,
   input  logic         mask,
   input  ovl_cfg_t     cfg,
   output logic [W-1:0] mix_out
);

   if (W < 1) begin : g_bad_w
      $error("edge_ovl_chan: W must be at least 1");
   end

   logic [W-1:0] mix_d;

   always_comb begin
      if (cfg.white && mask) mix_d = '1;
      else if (cfg.orig_bg)  mix_d = bg_in;
      else                   mix_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mix_out <= '0;
      else        mix_out <= mix_d;
   end

   // R5: white paint wins over the background
   p_white_paint_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.white && mask) |=> (mix_out == '1));

   // R3: black background where nothing is painted
   p_black_bg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cfg.white && mask) && !cfg.orig_bg) |=> (mix_out == '0));

   // R4: original background where nothing is painted
   p_orig_bg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cfg.white && mask) && cfg.orig_bg) |=> (mix_out == $past(bg_in)));

endmodule

// File: rtl/edge_ovl_mixer.sv
module edge_ovl_mixer
   import edge_ovl_pkg::*;
#(
   parameter int               RED_W     = 5,
   parameter int               GRN_W     = 6,
   parameter int               BLU_W     = 5,
   parameter int               ALIGN_DLY = 13,
   parameter logic [OVL_W-1:0] RST_MODE  = 2'b01,
   localparam int              PIX_W     = RED_W + GRN_W + BLU_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OVL_W-1:0] ovl_mode,
   input  logic [PIX_W-1:0] src_rgb,
   input  logic             msk_bit,
   input  logic             msk_vld,
   input  logic             msk_sof,
   input  logic             msk_sol,
   output logic [PIX_W-1:0] mix_rgb,
   output logic             mix_vld,
   output logic             mix_sof,
   output logic             mix_sol
);

   if (RED_W < 1 || GRN_W < 1 || BLU_W < 1) begin : g_bad_fields
      $error("edge_ovl_mixer: every colour field needs at least one bit");
   end

   logic [PIX_W-1:0] bg_rgb;
   ovl_cfg_t         cfg_eff;
   logic             frame_go;

   assign frame_go = msk_vld && msk_sof;

   edge_ovl_delay #(.W(PIX_W), .DEPTH(ALIGN_DLY)) u_align (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (src_rgb),
      .dout (bg_rgb)
   );

   edge_ovl_cfg #(.RST_MODE(RST_MODE)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_in (ovl_mode),
      .frame_go(frame_go),
      .cfg_eff (cfg_eff)
   );

   // Channel 0 is blue (lowest bits), 1 is green, 2 is red (highest bits)
   for (genvar c = 0; c < 3; c++) begin : g_chan
      localparam int W  = (c == 0) ? BLU_W : (c == 1) ? GRN_W : RED_W;
      localparam int LO = (c == 0) ? 0 : (c == 1) ? BLU_W : BLU_W + GRN_W;

      logic [W-1:0] ch_out;

      edge_ovl_chan #(.W(W)) u_mix (
         .clk    (clk),
         .rst_n  (rst_n),
         .bg_in  (bg_rgb[LO +: W]),
         .mask   (msk_bit),
         .cfg    (cfg_eff),
         .mix_out(ch_out)
      );

      assign mix_rgb[LO +: W] = ch_out;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mix_vld <= 1'b0;
         mix_sof <= 1'b0;
         mix_sol <= 1'b0;
      end else begin
         mix_vld <= msk_vld;
         mix_sof <= msk_sof;
         mix_sol <= msk_sol;
      end
   end

   // R9: tags follow the mask stream by exactly one cycle
   p_tags_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mix_vld == $past(msk_vld)) && (mix_sof == $past(msk_sof)) &&
               (mix_sol == $past(msk_sol)));

   // R1: outputs are cleared while reset is held
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (mix_rgb == '0) && !mix_vld && !mix_sof && !mix_sol);

endmodule

// File: tb/edge_ovl_mixer_test.sv
`timescale 1ns/1ps
module edge_ovl_mixer_test;

   localparam int  DLY      = 13;
   localparam time HALF_PER = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ovl_mode = 2'b00;
   logic [15:0] src_rgb = '0;
   logic        msk_bit = 1'b0;
   logic        msk_vld = 1'b0;
   logic        msk_sof = 1'b0;
   logic        msk_sol = 1'b0;
   logic [15:0] mix_rgb;
   logic        mix_vld;
   logic        mix_sof;
   logic        mix_sol;

   int          n_checks = 0;
   int          n_errors = 0;
   int          cyc = 0;
   logic [1:0]  model_cfg = 2'b01;

   always #(HALF_PER) clk = ~clk;

   edge_ovl_mixer uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .ovl_mode(ovl_mode),
      .src_rgb (src_rgb),
      .msk_bit (msk_bit),
      .msk_vld (msk_vld),
      .msk_sof (msk_sof),
      .msk_sol (msk_sol),
      .mix_rgb (mix_rgb),
      .mix_vld (mix_vld),
      .mix_sof (mix_sof),
      .mix_sol (mix_sol)
   );

   function automatic logic [15:0] pat(int c);
      return 16'(c * 40503 + 4660);
   endfunction

   task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h (step %0d)", req, act, exp, cyc);
      end
   endtask

   // One clock edge: drive at the falling edge, judge at the next falling edge
   task automatic step(logic mb, logic mv, logic sof, logic sol,
                       logic [1:0] mode, string req);
      logic [1:0]  eff;
      logic [15:0] bg;
      logic [15:0] exp;
      src_rgb  = pat(cyc);
      msk_bit  = mb;
      msk_vld  = mv;
      msk_sof  = sof;
      msk_sol  = sol;
      ovl_mode = mode;
      eff = (mv && sof) ? mode : model_cfg;
      if (mv && sof) model_cfg = mode;
      bg = (cyc >= DLY) ? pat(cyc - DLY) : 16'h0000;
      if (eff[1] && mb)  exp = 16'hFFFF;
      else if (eff[0])   exp = bg;
      else               exp = 16'h0000;
      @(posedge clk);
      @(negedge clk);
      check16(req, mix_rgb, exp);
      check16("R9", {13'd0, mix_vld, mix_sof, mix_sol}, {13'd0, mv, sof, sol});
      cyc++;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check16("R1", mix_rgb, 16'h0000);
      check16("R1", {13'd0, mix_vld, mix_sof, mix_sol}, 16'h0000);
      rst_n = 1'b1;
   endtask

   task automatic t_fill;
      // R2: background is zero until the alignment delay has filled
      step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, "R2");
      for (int i = 1; i < DLY + 2; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 2'b10, "R2");
      // R10: stored mode after reset shows the original background
      step(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, "R10");
      step(1'b0, 1'b1, 1'b0, 1'b0, 2'b10, "R10");
   endtask

   task automatic t_black;
      step(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, "R3");
      for (int i = 0; i < 4; i++) step(1'(i), 1'b1, 1'b0, 1'(i == 2), 2'b00, "R3");
   endtask

   task automatic t_orig;
      step(1'b0, 1'b1, 1'b1, 1'b1, 2'b01, "R4");
      for (int i = 0; i < 4; i++) step(1'(i), 1'b1, 1'b0, 1'b0, 2'b01, "R4");
   endtask

   task automatic t_white_orig;
      step(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, "R5");
      for (int i = 0; i < 4; i++) step(1'(i), 1'b1, 1'b0, 1'b0, 2'b11, "R5");
   endtask

   task automatic t_white_black;
      step(1'b0, 1'b1, 1'b1, 1'b1, 2'b10, "R6");
      for (int i = 0; i < 4; i++) step(1'(i), 1'b1, 1'b0, 1'b0, 2'b10, "R6");
   endtask

   task automatic t_mid_frame;
      step(1'b0, 1'b1, 1'b1, 1'b1, 2'b01, "R7");
      // mode changes with no frame start: must stay on original background
      step(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, "R7");
      step(1'b1, 1'b1, 1'b0, 1'b1, 2'b10, "R7");
      // frame-start flag without valid: still ignored
      step(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, "R7");
      step(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, "R7");
   endtask

   task automatic t_same_cycle;
      // R8: the frame-start pixel already obeys the new mode
      step(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, "R8");
      step(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, "R8");
      step(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, "R8");
      step(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, "R8");
      step(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, "R8");
   endtask

   initial begin
      #(HALF_PER * 2 * 200000);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset;
      t_fill;
      t_black;
      t_orig;
      t_white_orig;
      t_white_black;
      t_mid_frame;
      t_same_cycle;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule